// File: doc/BRIEF.md
# VGA Planar Memory Write Path

This block turns one byte written by the host into the legacy video memory window into a single write on a 32-bit video RAM port. Each RAM word holds one byte for each of four planes, and every lane has its own byte enable. The block first places the window offset according to the memory-map select. It then steers the byte in one of three ways. In chain-4 it goes to one lane chosen by the address. In odd/even it goes to an interleaved lane. In planar access it passes through the full write pipeline: rotate and set/reset, latch copy, colour fill, or masked fill, then a logic function against the latch, then a per-bit mask merge with the latch.

The configuration fields come from the sequencer and graphics register file, which sits outside this block. The 32-bit latch comes from the read path. A registered state machine classifies every request at the clock edge and drives the RAM port for the following cycle. Its states are:
- `ST_IDLE`: no request.
- `ST_DISCARD`: the request was dropped.
- `ST_CHAIN4`, `ST_ODDEVEN`, `ST_PLANAR`: a write is issued through that path.

Every state is re-entered from any state on the next request. The transitions are:
- *no request* leads to `ST_IDLE`.
- *outside window* or *lane disabled* leads to `ST_DISCARD`.
- *chain-4 hit*, *odd/even hit* and *planar hit* lead to the matching write state.

Top module: `vga_planar_write`

## Requirements
- R1: `cfg_map_sel` selects the window. 0 accepts the whole 128 KiB offset range unchanged. 1 accepts offsets below 0x10000. 2 accepts [0x10000, 0x18000) and rebases it by subtracting 0x10000. 3 accepts [0x18000, 0x20000) and rebases it by subtracting 0x18000. A request outside the selected window issues no write.
- R2: When `cfg_chain4` is 1, the lane is offset bits 1:0 and the word address is the offset shifted right by 2. `mem_byte_en` is one-hot on that lane, and `mem_wdata` is the data byte repeated in all four lanes. The write is dropped if `cfg_plane_en` has that lane's bit clear.
- R3: When `cfg_chain4` is 0 and `cfg_odd_even` is 1, the lane is {`cfg_page_sel`, offset bit 0} and the word address is the offset shifted right by 1. The write is gated by `cfg_plane_en` for that lane. Chain-4 takes priority over odd/even.
- R4: In planar write mode 0, the data byte is rotated right by `cfg_rotate` and repeated to every plane. Each plane whose `cfg_sr_enable` bit is set takes instead 0xFF or 0x00 from its `cfg_sr_value` bit. The bit mask is `cfg_bit_mask`.
- R5: In planar write mode 1, the latch is written unchanged. The logic function and the bit mask are skipped.
- R6: In planar write mode 2, data bit p fills plane p with 0xFF or 0x00. The bit mask is `cfg_bit_mask`.
- R7: In planar write mode 3, the value is the plane fill from `cfg_sr_value`. The bit mask is `cfg_bit_mask` ANDed with the rotated data byte.
- R8: `cfg_logic_fn` combines the value with the latch before masking: 0 passes it, 1 ANDs it, 2 ORs it, 3 XORs it.
- R9: The 8-bit mask applies to every plane. A set mask bit takes the new value and a clear bit keeps the latch bit.
- R10: A planar write uses `cfg_plane_en` as its byte enables and the low 16 bits of the window offset as the word address. An all-zero plane enable issues no write.
- R11: A request sampled at a clock edge drives the RAM port during the following cycle only. A cycle without a request drives `mem_we` low and all byte enables low.
- R12: A rotate count of 0 leaves the byte unchanged, and rotation wraps within 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request this cycle |
| wr_offset | input | 17 | Byte offset within the 128 KiB legacy window |
| wr_data | input | 8 | Byte written by the host |
| latch_in | input | 32 | Current four-plane latch |
| cfg_plane_en | input | 4 | Plane write enables |
| cfg_chain4 | input | 1 | Chain-4 steering |
| cfg_odd_even | input | 1 | Odd/even steering |
| cfg_page_sel | input | 1 | Upper plane-pair select for odd/even |
| cfg_map_sel | input | 2 | Memory-map window select |
| cfg_write_mode | input | 2 | Planar write mode 0..3 |
| cfg_rotate | input | 3 | Right-rotate count |
| cfg_logic_fn | input | 2 | Logic function against the latch |
| cfg_sr_value | input | 4 | Set/reset value per plane |
| cfg_sr_enable | input | 4 | Set/reset enable per plane |
| cfg_bit_mask | input | 8 | Bit mask |
| mem_we | output | 1 | RAM write strobe |
| mem_word_addr | output | 16 | RAM word address |
| mem_byte_en | output | 4 | Per-plane byte enables |
| mem_wdata | output | 32 | RAM write data, plane p in bits 8p+7..8p |

## Verification
The bench targets the window edges at 0x10000, 0x18000 and 0x1FFFF. A design with an off-by-one or missing rebase writes a discarded byte or writes to a shifted word. It drives chain-4 and odd/even together and clears single plane enables. A design with the wrong priority, or without the lane gate, picks the wrong lane or writes a masked plane. In planar access it checks rotation by 0, 1 and 7, a partial bit mask in fill and masked-fill modes, and each logic function. A wrong rotate direction, a mask that is not merged with the latch, or a logic function or mask wrongly applied in latch-copy mode each give a different word.

// File: rtl/vga_wr_pkg.sv
`timescale 1ns/1ps
package vga_wr_pkg;

    localparam int PLANES      = 4;
    localparam int LANE_W      = 8;
    localparam int DATA_W      = PLANES * LANE_W;
    localparam int PLANE_SEL_W = $clog2(PLANES);
    localparam int ROT_W       = $clog2(LANE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCARD,
        ST_CHAIN4,
        ST_ODDEVEN,
        ST_PLANAR
    } wr_state_e;

    typedef enum logic [1:0] {
        WM_ROTATE = 2'd0,
        WM_LATCH  = 2'd1,
        WM_FILL   = 2'd2,
        WM_MASKED = 2'd3
    } wr_mode_e;

    typedef enum logic [1:0] {
        LF_PASS = 2'd0,
        LF_AND  = 2'd1,
        LF_OR   = 2'd2,
        LF_XOR  = 2'd3
    } logic_fn_e;

    // Right rotate within one lane; a count of zero returns the input.
    function automatic logic [LANE_W-1:0] lane_rotr(input logic [LANE_W-1:0] b,
                                                    input logic [ROT_W-1:0] amt);
        logic [2*LANE_W-1:0] twice;
        twice = {b, b} >> amt;
        return twice[LANE_W-1:0];
    endfunction

    // One bit per plane becomes a full lane of ones or zeros.
    function automatic logic [DATA_W-1:0] plane_fill(input logic [PLANES-1:0] bits);
        logic [DATA_W-1:0] r;
        for (int p = 0; p < PLANES; p++) begin
            r[p*LANE_W +: LANE_W] = {LANE_W{bits[p]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/vga_wr_window.sv
`timescale 1ns/1ps
module vga_wr_window
    import vga_wr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] offset_in,
    input  logic [1:0]        map_sel,
    output logic              hit,
    output logic [ADDR_W-1:0] rebased
);
    localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);
    localparam logic [ADDR_W-1:0] QTR  = ADDR_W'(1) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HI_Q = HALF + QTR;

    always_comb begin
        unique case (map_sel)
            2'd0: begin
                hit     = 1'b1;
                rebased = offset_in;
            end
            2'd1: begin
                hit     = (offset_in < HALF);
                rebased = offset_in;
            end
            2'd2: begin
                hit     = (offset_in >= HALF) && (offset_in < HI_Q);
                rebased = offset_in - HALF;
            end
            default: begin
                hit     = (offset_in >= HI_Q);
                rebased = offset_in - HI_Q;
            end
        endcase
    end

    // R1: a rebased hit in the two small windows stays inside one quarter
    always_comb begin
        if (!$isunknown({offset_in, map_sel}) && hit && map_sel[1]) begin
            a_rebase_in_quarter_r1: assert (rebased < QTR);
        end
    end

endmodule

// File: rtl/vga_wr_steer.sv
`timescale 1ns/1ps
module vga_wr_steer
    import vga_wr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int WORD_W = 16
) (
    input  logic [ADDR_W-1:0] offset_in,
    input  logic              chain4,
    input  logic              page_sel,
    input  logic [PLANES-1:0] plane_en,
    output logic [WORD_W-1:0] word_addr,
    output logic [PLANES-1:0] lane_be,
    output logic              lane_open
);
    logic [PLANE_SEL_W-1:0] lane;

    always_comb begin
        if (chain4) begin
            lane      = offset_in[PLANE_SEL_W-1:0];
            word_addr = WORD_W'(offset_in >> PLANE_SEL_W);
        end else begin
            lane      = PLANE_SEL_W'({page_sel, offset_in[0]});
            word_addr = WORD_W'(offset_in >> 1);
        end
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        assign lane_be[p] = (lane == PLANE_SEL_W'(p));
    end

    assign lane_open = |(lane_be & plane_en);

endmodule

// File: rtl/vga_wr_planar.sv
`timescale 1ns/1ps
module vga_wr_planar
    import vga_wr_pkg::*;
(
    input  logic [1:0]        write_mode,
    input  logic [ROT_W-1:0]  rotate,
    input  logic [1:0]        logic_fn,
    input  logic [PLANES-1:0] sr_value,
    input  logic [PLANES-1:0] sr_enable,
    input  logic [LANE_W-1:0] bit_mask,
    input  logic [LANE_W-1:0] data_in,
    input  logic [DATA_W-1:0] latch_in,
    output logic [DATA_W-1:0] wdata
);
    logic [LANE_W-1:0] rot_byte;
    logic [DATA_W-1:0] mode0_val;
    logic [DATA_W-1:0] src_val;
    logic [LANE_W-1:0] mask8;
    logic [DATA_W-1:0] mask32;
    logic [DATA_W-1:0] alu_val;
    logic [DATA_W-1:0] merged;

    assign rot_byte = lane_rotr(data_in, rotate);

    // Mode 0 set/reset substitution, one lane per plane
    for (genvar p = 0; p < PLANES; p++) begin : g_setreset
        assign mode0_val[p*LANE_W +: LANE_W] =
            sr_enable[p] ? {LANE_W{sr_value[p]}} : rot_byte;
    end

    always_comb begin
        unique case (wr_mode_e'(write_mode))
            WM_ROTATE: begin
                src_val = mode0_val;
                mask8   = bit_mask;
            end
            WM_LATCH: begin
                src_val = latch_in;
                mask8   = '1;
            end
            WM_FILL: begin
                src_val = plane_fill(data_in[PLANES-1:0]);
                mask8   = bit_mask;
            end
            WM_MASKED: begin
                src_val = plane_fill(sr_value);
                mask8   = bit_mask & rot_byte;
            end
        endcase
    end

    always_comb begin
        unique case (logic_fn_e'(logic_fn))
            LF_PASS: alu_val = src_val;
            LF_AND:  alu_val = src_val & latch_in;
            LF_OR:   alu_val = src_val | latch_in;
            LF_XOR:  alu_val = src_val ^ latch_in;
        endcase
    end

    assign mask32 = {PLANES{mask8}};
    assign merged = (alu_val & mask32) | (latch_in & ~mask32);
    assign wdata  = (wr_mode_e'(write_mode) == WM_LATCH) ? latch_in : merged;

endmodule

// File: rtl/vga_planar_write.sv
`timescale 1ns/1ps
module vga_planar_write
    import vga_wr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_offset,
    input  logic [LANE_W-1:0]   wr_data,
    input  logic [DATA_W-1:0]   latch_in,
    input  logic [PLANES-1:0]   cfg_plane_en,
    input  logic                cfg_chain4,
    input  logic                cfg_odd_even,
    input  logic                cfg_page_sel,
    input  logic [1:0]          cfg_map_sel,
    input  logic [1:0]          cfg_write_mode,
    input  logic [ROT_W-1:0]    cfg_rotate,
    input  logic [1:0]          cfg_logic_fn,
    input  logic [PLANES-1:0]   cfg_sr_value,
    input  logic [PLANES-1:0]   cfg_sr_enable,
    input  logic [LANE_W-1:0]   cfg_bit_mask,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_word_addr,
    output logic [PLANES-1:0]   mem_byte_en,
    output logic [DATA_W-1:0]   mem_wdata
);
    wr_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic [PLANES-1:0] be_q, be_d;
    logic [DATA_W-1:0] data_q, data_d;

    logic              win_hit;
    logic [ADDR_W-1:0] win_off;
    logic [WORD_W-1:0] steer_word;
    logic [PLANES-1:0] steer_be;
    logic              steer_open;
    logic [DATA_W-1:0] planar_wdata;

    vga_wr_window #(.ADDR_W(ADDR_W)) u_window (
        .offset_in (wr_offset),
        .map_sel   (cfg_map_sel),
        .hit       (win_hit),
        .rebased   (win_off)
    );

    vga_wr_steer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_steer (
        .offset_in (win_off),
        .chain4    (cfg_chain4),
        .page_sel  (cfg_page_sel),
        .plane_en  (cfg_plane_en),
        .word_addr (steer_word),
        .lane_be   (steer_be),
        .lane_open (steer_open)
    );

    vga_wr_planar u_planar (
        .write_mode (cfg_write_mode),
        .rotate     (cfg_rotate),
        .logic_fn   (cfg_logic_fn),
        .sr_value   (cfg_sr_value),
        .sr_enable  (cfg_sr_enable),
        .bit_mask   (cfg_bit_mask),
        .data_in    (wr_data),
        .latch_in   (latch_in),
        .wdata      (planar_wdata)
    );

    // Next state: which path the request takes, with chain-4 first
    always_comb begin
        if (!wr_valid) begin
            state_d = ST_IDLE;
        end else if (!win_hit) begin
            state_d = ST_DISCARD;
        end else if (cfg_chain4) begin
            state_d = steer_open ? ST_CHAIN4 : ST_DISCARD;
        end else if (cfg_odd_even) begin
            state_d = steer_open ? ST_ODDEVEN : ST_DISCARD;
        end else begin
            state_d = (|cfg_plane_en) ? ST_PLANAR : ST_DISCARD;
        end
    end

    always_comb begin
        if (state_d == ST_PLANAR) begin
            word_d = WORD_W'(win_off);
            be_d   = cfg_plane_en;
            data_d = planar_wdata;
        end else begin
            word_d = steer_word;
            be_d   = steer_be;
            data_d = {PLANES{wr_data}};
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            be_q    <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
            be_q    <= be_d;
            data_q  <= data_d;
        end
    end

    // Outputs from state
    always_comb begin
        mem_word_addr = word_q;
        mem_wdata     = data_q;
        unique case (state_q)
            ST_CHAIN4, ST_ODDEVEN, ST_PLANAR: begin
                mem_we      = 1'b1;
                mem_byte_en = be_q;
            end
            ST_IDLE, ST_DISCARD: begin
                mem_we      = 1'b0;
                mem_byte_en = '0;
            end
            default: begin
                mem_we      = 1'b0;
                mem_byte_en = '0;
            end
        endcase
    end

    p_discard_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !win_hit) |=> !mem_we);

    p_single_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHAIN4 || state_q == ST_ODDEVEN) |-> $onehot(mem_byte_en));

    p_lane_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && win_hit && (cfg_chain4 || cfg_odd_even) && !steer_open) |=> !mem_we);

    p_write_has_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_byte_en != '0));

    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (!mem_we && mem_byte_en == '0));

endmodule

// File: tb/tb_vga_planar_write.sv
`timescale 1ns/1ps
module tb_vga_planar_write;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_offset = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] latch_in = '0;
    logic [3:0]  cfg_plane_en = 4'hF;
    logic        cfg_chain4 = 1'b0;
    logic        cfg_odd_even = 1'b0;
    logic        cfg_page_sel = 1'b0;
    logic [1:0]  cfg_map_sel = 2'd0;
    logic [1:0]  cfg_write_mode = 2'd0;
    logic [2:0]  cfg_rotate = 3'd0;
    logic [1:0]  cfg_logic_fn = 2'd0;
    logic [3:0]  cfg_sr_value = 4'h0;
    logic [3:0]  cfg_sr_enable = 4'h0;
    logic [7:0]  cfg_bit_mask = 8'hFF;
    logic        mem_we;
    logic [15:0] mem_word_addr;
    logic [3:0]  mem_byte_en;
    logic [31:0] mem_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vga_planar_write dut (
        .clk, .rst_n, .wr_valid, .wr_offset, .wr_data, .latch_in,
        .cfg_plane_en, .cfg_chain4, .cfg_odd_even, .cfg_page_sel,
        .cfg_map_sel, .cfg_write_mode, .cfg_rotate, .cfg_logic_fn,
        .cfg_sr_value, .cfg_sr_enable, .cfg_bit_mask,
        .mem_we, .mem_word_addr, .mem_byte_en, .mem_wdata
    );

    // Vector: mode rot fn srv sre mask pe data latch | exp_wdata exp_be
    localparam int VW = 103;
    localparam int NV = 11;
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0,3'd0,2'd0,4'h0,4'h0,8'hFF,4'hF,8'h3C,32'h12345678,32'h3C3C3C3C,4'hF}, // R4 R12
        {2'd0,3'd1,2'd0,4'h0,4'h0,8'hFF,4'hF,8'h81,32'h12345678,32'hC0C0C0C0,4'hF}, // R4 R12
        {2'd0,3'd0,2'd0,4'h1,4'h5,8'hFF,4'hF,8'h00,32'h12345678,32'h000000FF,4'hF}, // R4
        {2'd1,3'd0,2'd3,4'h0,4'h0,8'h00,4'h6,8'hFF,32'h12345678,32'h12345678,4'h6}, // R5
        {2'd2,3'd0,2'd0,4'h0,4'h0,8'hF0,4'hF,8'hFA,32'h12345678,32'hF204F608,4'hF}, // R6 R9
        {2'd3,3'd4,2'd0,4'h3,4'h0,8'hFF,4'hF,8'h0F,32'h12345678,32'h0204F6F8,4'hF}, // R7
        {2'd0,3'd0,2'd1,4'h0,4'h0,8'hFF,4'hF,8'hF0,32'h12345678,32'h10305070,4'hF}, // R8
        {2'd0,3'd0,2'd2,4'h0,4'h0,8'hFF,4'hF,8'h0F,32'h12345678,32'h1F3F5F7F,4'hF}, // R8
        {2'd0,3'd0,2'd3,4'h0,4'h0,8'hFF,4'hF,8'hFF,32'h12345678,32'hEDCBA987,4'hF}, // R8
        {2'd2,3'd0,2'd0,4'h0,4'h0,8'hFF,4'h0,8'hFF,32'h12345678,32'h00000000,4'h0}, // R10
        {2'd0,3'd7,2'd0,4'h0,4'h0,8'hFF,4'h3,8'h01,32'h12345678,32'h02020202,4'h3}  // R12
    };

    task automatic check(input string req, input bit exp_we, input logic [15:0] exp_word,
                         input logic [3:0] exp_be, input logic [31:0] exp_data);
        n_checks++;
        if (exp_we) begin
            if (mem_we !== 1'b1 || mem_word_addr !== exp_word ||
                mem_byte_en !== exp_be || mem_wdata !== exp_data) begin
                n_fail++;
                $display("FAIL %s: we=%b word=%h be=%h data=%h, expected we=1 word=%h be=%h data=%h",
                         req, mem_we, mem_word_addr, mem_byte_en, mem_wdata,
                         exp_word, exp_be, exp_data);
            end
        end else if (mem_we !== 1'b0 || mem_byte_en !== 4'h0) begin
            n_fail++;
            $display("FAIL %s: we=%b be=%h, expected we=0 be=0", req, mem_we, mem_byte_en);
        end
    endtask

    // Drive a request for one cycle, then sample the registered port.
    task automatic issue(input logic [16:0] off, input logic [7:0] d);
        wr_offset = off;
        wr_data   = d;
        wr_valid  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_valid  = 1'b0;
    endtask

    task automatic steer_cfg(input bit c4, input bit oe, input bit pg, input logic [3:0] pe,
                             input logic [1:0] map);
        cfg_chain4   = c4;
        cfg_odd_even = oe;
        cfg_page_sel = pg;
        cfg_plane_en = pe;
        cfg_map_sel  = map;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", 1'b0, 16'h0, 4'h0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", 1'b0, 16'h0, 4'h0, 32'h0);

        // Planar vector table, map 0, offset 0x01234
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            steer_cfg(1'b0, 1'b0, 1'b0, v[79:76], 2'd0);
            cfg_write_mode = v[102:101];
            cfg_rotate     = v[100:98];
            cfg_logic_fn   = v[97:96];
            cfg_sr_value   = v[95:92];
            cfg_sr_enable  = v[91:88];
            cfg_bit_mask   = v[87:80];
            latch_in       = v[67:36];
            issue(17'h01234, v[75:68]);
            check($sformatf("R4-R10 planar vector %0d", i), v[3:0] != 4'h0, 16'h1234,
                  v[3:0], v[35:4]);
        end
        cfg_write_mode = 2'd0; cfg_rotate = 3'd0; cfg_logic_fn = 2'd0;
        cfg_sr_enable = 4'h0; cfg_bit_mask = 8'hFF;

        // R11: the write lasts one cycle only
        @(negedge clk);
        check("R11 no request", 1'b0, 16'h0, 4'h0, 32'h0);

        // R2 chain-4
        steer_cfg(1'b1, 1'b0, 1'b0, 4'hF, 2'd0);
        issue(17'h00006, 8'h5A);
        check("R2 chain4 lane 2", 1'b1, 16'h0001, 4'h4, 32'h5A5A5A5A);
        steer_cfg(1'b1, 1'b0, 1'b0, 4'hB, 2'd0);
        issue(17'h00006, 8'h5A);
        check("R2 chain4 lane masked", 1'b0, 16'h0, 4'h0, 32'h0);
        steer_cfg(1'b1, 1'b1, 1'b1, 4'hF, 2'd0);
        issue(17'h00005, 8'h33);
        check("R3 chain4 over odd/even", 1'b1, 16'h0001, 4'h2, 32'h33333333);

        // R3 odd/even
        steer_cfg(1'b0, 1'b1, 1'b1, 4'hF, 2'd0);
        issue(17'h00013, 8'hC7);
        check("R3 odd/even plane 3", 1'b1, 16'h0009, 4'h8, 32'hC7C7C7C7);
        steer_cfg(1'b0, 1'b1, 1'b0, 4'hE, 2'd0);
        issue(17'h00010, 8'hC7);
        check("R3 odd/even plane 0 masked", 1'b0, 16'h0, 4'h0, 32'h0);

        // R1 window decode, planar pass-through of 0x5A
        latch_in = 32'h0;
        steer_cfg(1'b0, 1'b0, 1'b0, 4'hF, 2'd1);
        issue(17'h10000, 8'h5A);
        check("R1 map1 above edge", 1'b0, 16'h0, 4'h0, 32'h0);
        issue(17'h0FFFF, 8'h5A);
        check("R1 map1 last byte", 1'b1, 16'hFFFF, 4'hF, 32'h5A5A5A5A);
        steer_cfg(1'b0, 1'b0, 1'b0, 4'hF, 2'd2);
        issue(17'h10010, 8'h5A);
        check("R1 map2 rebased", 1'b1, 16'h0010, 4'hF, 32'h5A5A5A5A);
        issue(17'h18000, 8'h5A);
        check("R1 map2 upper edge", 1'b0, 16'h0, 4'h0, 32'h0);
        issue(17'h0FFFF, 8'h5A);
        check("R1 map2 below base", 1'b0, 16'h0, 4'h0, 32'h0);
        steer_cfg(1'b0, 1'b0, 1'b0, 4'hF, 2'd3);
        issue(17'h18004, 8'h5A);
        check("R1 map3 rebased", 1'b1, 16'h0004, 4'hF, 32'h5A5A5A5A);
        issue(17'h00004, 8'h5A);
        check("R1 map3 low offset", 1'b0, 16'h0, 4'h0, 32'h0);
        steer_cfg(1'b0, 1'b0, 1'b0, 4'hF, 2'd0);
        issue(17'h1FFFF, 8'h5A);
        check("R10 map0 top word", 1'b1, 16'hFFFF, 4'hF, 32'h5A5A5A5A);
        steer_cfg(1'b1, 1'b0, 1'b0, 4'hF, 2'd3);
        issue(17'h1800B, 8'h66);
        check("R1 R2 map3 chain4", 1'b1, 16'h0002, 4'h8, 32'h66666666);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule